// File: doc/BRIEF.md
# Partially Decoded Expansion Port with Burst Buffer

This block sits on the peripheral side of an 8-bit expansion bus that has separate I/O and memory spaces. It watches the 16-bit address, the active-low strobes /IORQ, /MREQ, /RD and /WR, and the split data bus. It claims a cycle only when a partial address pattern matches. The pattern keeps clear of the built-in video controller, the gate array and the floppy controller. Bytes written to the data port go into a small first-in first-out buffer, and reads take them back out in the same order.

The decoder ignores A9 and A8 on purpose. Single-step block I/O instructions change the upper address byte after every transfer, so up to four of them run back to back still reach the same port. A repeating block I/O instruction is not supported. A control register holds a memory-mapped mode flag. When the flag is set, memory cycles inside a small window also act as the data port, so that block-copy instructions can stream bytes through it. Every access takes effect exactly once, on the first clock edge that sees its strobe active.

Top module: `exp_port`

## Requirements
- R1: An I/O write is a cycle with /IORQ and /WR both low, and an I/O read is a cycle with /IORQ and /RD both low. Each strobe acts once, on the first clock edge at which it is seen low. Holding a strobe low over several clocks never pushes or pops a second time.
- R2: An I/O cycle is claimed only if A15=1, A14=1, A10=0 and A7=1. Any other I/O address has no effect on the buffer and never asserts `dout_en`.
- R3: A13..A11, A9 and A8 are not decoded. Addresses 0xF880, 0xF980, 0xFA80 and 0xFB80 all reach the same data port.
- R4: A6..A0 must equal the parameter `BASE_LO` (default 0) to select the data port, or `BASE_LO+1` to select the control port. Any other value is ignored.
- R5: Data-port writes fill a 4-entry buffer, and data-port reads return the bytes in the order they were written.
- R6: A data-port read while the buffer is empty returns 0xFF.
- R7: A data-port write while the buffer is full is dropped and leaves the stored bytes unchanged. It also sets a sticky overflow flag, which reads back as bit 7 of the control port and stays set until reset.
- R8: A control-port write loads the mode flag from data bit 0. A control-port read returns the overflow flag in bit 7 and the mode flag in bit 0, with bits 6..1 zero.
- R9: While the mode flag is 1, memory cycles (/MREQ low with /RD or /WR low) whose address lies in the window 0x4000..0x4003 act as data-port accesses. While the flag is 0, and for any address outside the window, memory cycles are ignored.
- R10: `dout_en` is high while a claimed read strobe is low. The byte read appears on `dout` from the clock edge that acts on the strobe, and `dout` holds its value until the next acted-on read.
- R11: After reset the buffer is empty, the mode and overflow flags are 0, and `dout_en` is low while no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Bus address A15..A0 |
| din | input | 8 | Data driven by the host on writes |
| dout | output | 8 | Data returned on reads |
| dout_en | output | 1 | High while this block should drive the data bus |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |

## Verification
Two things can happen on the same edge. A data write that finds the buffer full must be rejected while the overflow flag is set. The bench provokes this with a fifth write after four stored bytes. It then judges both outcomes: a control read must return bit 7 set, and the next four data reads, made through different A9/A8 aliases, must return the original four bytes in order. The second coincidence is a held strobe against the single-action rule. Reads and writes are held low for several clocks, and the scoreboard checks that every later read still returns the next expected byte.

// File: rtl/exp_port_pkg.sv
package exp_port_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_DATA = 2'd1,
      TGT_CTRL = 2'd2
   } tgt_e;

   localparam int CTRL_MODE_BIT = 0;
   localparam int CTRL_OVF_BIT  = 7;
   localparam int BUS_DW        = 8;
   localparam int BUS_AW        = 16;
endpackage

// File: rtl/exp_port_decode.sv
module exp_port_decode
   import exp_port_pkg::*;
#(
   parameter logic [6:0]  BASE_LO      = 7'h00,
   parameter bit          MEM_MAP_EN   = 1'b1,
   parameter logic [15:0] MEM_WIN_BASE = 16'h4000,
   parameter int          MEM_WIN_LOG2 = 2
) (
   input  logic [15:0] addr,
   input  logic        iorq_n,
   input  logic        mreq_n,
   input  logic        mm_en,
   output tgt_e        tgt
);
   localparam logic [6:0] BASE_CTRL = BASE_LO + 7'd1;

   logic io_common;
   logic mem_hit;
   logic unused_bits;

   // Upper-page bits that steer clear of video, gate array and disk ranges
   assign io_common   = addr[15] & addr[14] & ~addr[10] & addr[7];
   assign unused_bits = ^{addr[13:11], addr[9:8]};

   generate
      if (MEM_MAP_EN) begin : g_mem
         assign mem_hit = ~mreq_n & mm_en &
            (addr[15:MEM_WIN_LOG2] == MEM_WIN_BASE[15:MEM_WIN_LOG2]);
      end else begin : g_nomem
         assign mem_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      tgt = TGT_NONE;
      if (!iorq_n) begin
         if (io_common && addr[6:0] == BASE_LO)
            tgt = TGT_DATA;
         else if (io_common && addr[6:0] == BASE_CTRL)
            tgt = TGT_CTRL;
      end else if (mem_hit) begin
         tgt = TGT_DATA;
      end
   end
endmodule

// File: rtl/exp_port_strobe.sv
module exp_port_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic iorq_n,
   input  logic mreq_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic rd_lv,
   output logic wr_lv,
   output logic rd_evt,
   output logic wr_evt
);
   logic cyc;
   logic rd_prev;
   logic wr_prev;

   assign cyc   = ~iorq_n | ~mreq_n;
   assign rd_lv = cyc & ~rd_n;
   assign wr_lv = cyc & ~wr_n;

   // Previous-level registers start high so a strobe held through reset is not counted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev <= 1'b1;
         wr_prev <= 1'b1;
      end else begin
         rd_prev <= rd_lv;
         wr_prev <= wr_lv;
      end
   end

   assign rd_evt = rd_lv & ~rd_prev;
   assign wr_evt = wr_lv & ~wr_prev;
endmodule

// File: rtl/exp_port_fifo.sv
module exp_port_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic [DW-1:0]               wdata,
   input  logic                        pop,
   output logic [DW-1:0]               head,
   output logic                        full,
   output logic                        empty,
   output logic [$clog2(DEPTH):0]      count
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("exp_port_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wptr;
   logic [AW:0]   rptr;

   assign count = wptr - rptr;
   assign full  = (count == FULL_CNT);
   assign empty = (wptr == rptr);
   assign head  = mem[rptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (push && !full)  wptr <= wptr + 1'b1;
         if (pop && !empty)  rptr <= rptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[wptr[AW-1:0]] <= wdata;
   end
endmodule

// File: rtl/exp_port.sv
module exp_port
   import exp_port_pkg::*;
#(
   parameter int          FIFO_DEPTH   = 4,
   parameter logic [6:0]  BASE_LO      = 7'h00,
   parameter bit          MEM_MAP_EN   = 1'b1,
   parameter logic [15:0] MEM_WIN_BASE = 16'h4000,
   parameter int          MEM_WIN_LOG2 = 2,
   parameter logic [7:0]  EMPTY_FILL   = 8'hFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] addr,
   input  logic [7:0]  din,
   output logic [7:0]  dout,
   output logic        dout_en,
   input  logic        iorq_n,
   input  logic        mreq_n,
   input  logic        rd_n,
   input  logic        wr_n
);
   localparam int CW = $clog2(FIFO_DEPTH) + 1;

   generate
      if (BASE_LO == 7'h7F) begin : g_bad_base
         $error("exp_port: BASE_LO+1 must fit in seven bits");
      end
      if (MEM_WIN_LOG2 < 0 || MEM_WIN_LOG2 > 8) begin : g_bad_win
         $error("exp_port: MEM_WIN_LOG2 out of range");
      end
   endgenerate

   tgt_e          tgt;
   logic          mm_en;
   logic          ovf;
   logic          rd_lv, wr_lv, rd_evt, wr_evt;
   logic [7:0]    head;
   logic          fifo_full, fifo_empty;
   logic [CW-1:0] fifo_count;
   logic [7:0]    rd_q;
   logic [7:0]    ctrl_rd;
   logic          do_push, do_pop, do_ctrl_wr;

   exp_port_decode #(
      .BASE_LO      (BASE_LO),
      .MEM_MAP_EN   (MEM_MAP_EN),
      .MEM_WIN_BASE (MEM_WIN_BASE),
      .MEM_WIN_LOG2 (MEM_WIN_LOG2)
   ) u_dec (
      .addr   (addr),
      .iorq_n (iorq_n),
      .mreq_n (mreq_n),
      .mm_en  (mm_en),
      .tgt    (tgt)
   );

   exp_port_strobe u_stb (
      .clk    (clk),
      .rst_n  (rst_n),
      .iorq_n (iorq_n),
      .mreq_n (mreq_n),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .rd_lv  (rd_lv),
      .wr_lv  (wr_lv),
      .rd_evt (rd_evt),
      .wr_evt (wr_evt)
   );

   assign do_push    = wr_evt & (tgt == TGT_DATA);
   assign do_pop     = rd_evt & (tgt == TGT_DATA);
   assign do_ctrl_wr = wr_evt & (tgt == TGT_CTRL);

   exp_port_fifo #(.DW(BUS_DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (do_push),
      .wdata (din),
      .pop   (do_pop),
      .head  (head),
      .full  (fifo_full),
      .empty (fifo_empty),
      .count (fifo_count)
   );

   always_comb begin
      ctrl_rd                = '0;
      ctrl_rd[CTRL_OVF_BIT]  = ovf;
      ctrl_rd[CTRL_MODE_BIT] = mm_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mm_en <= 1'b0;
         ovf   <= 1'b0;
         rd_q  <= '0;
      end else begin
         if (do_ctrl_wr)             mm_en <= din[CTRL_MODE_BIT];
         if (do_push && fifo_full)   ovf   <= 1'b1;
         if (rd_evt) begin
            case (tgt)
               TGT_DATA: rd_q <= fifo_empty ? EMPTY_FILL : head;
               TGT_CTRL: rd_q <= ctrl_rd;
               default:  rd_q <= rd_q;
            endcase
         end
      end
   end

   assign dout    = rd_q;
   assign dout_en = rd_lv & (tgt != TGT_NONE);
endmodule

// File: rtl/exp_port_chk.sv
module exp_port_chk #(
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [15:0]   addr,
   input logic          iorq_n,
   input logic          mreq_n,
   input logic [7:0]    dout,
   input logic          dout_en,
   input logic          rd_lv,
   input logic          wr_lv,
   input logic          rd_evt,
   input logic          wr_evt,
   input logic          tgt_data,
   input logic          fifo_full,
   input logic          fifo_empty,
   input logic [CW-1:0] fifo_count,
   input logic          ovf,
   input logic          mm_en
);
   AST_WR_HELD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lv && $past(wr_lv)) |-> !wr_evt);                                  // R1
   AST_RD_HELD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lv && $past(rd_lv)) |-> !rd_evt);                                  // R1
   AST_A10_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!iorq_n && mreq_n && addr[10]) |-> !dout_en);                         // R2
   AST_EMPTY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_evt && tgt_data && fifo_empty) |=> (dout == 8'hFF));               // R6
   AST_FULL_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && tgt_data && fifo_full) |=> ovf);                            // R7
   AST_FULL_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && tgt_data && fifo_full && !rd_evt) |=> fifo_full);           // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);                                                          // R7
   AST_MEM_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (iorq_n && !mm_en) |-> !dout_en);                                      // R9
   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_evt |=> $stable(dout));                                            // R10
   AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CW'(1 << (CW - 1)));                                     // R5
endmodule

bind exp_port exp_port_chk #(.CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr       (addr),
   .iorq_n     (iorq_n),
   .mreq_n     (mreq_n),
   .dout       (dout),
   .dout_en    (dout_en),
   .rd_lv      (rd_lv),
   .wr_lv      (wr_lv),
   .rd_evt     (rd_evt),
   .wr_evt     (wr_evt),
   .tgt_data   (do_push | do_pop | (tgt == exp_port_pkg::TGT_DATA)),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty),
   .fifo_count (fifo_count),
   .ovf        (ovf),
   .mm_en      (mm_en)
);

// File: tb/exp_port_bench.sv
`timescale 1ns/1ps
module exp_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        dout_en;
   logic        iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit sample_req = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] mdl[$];
   bit         mdl_ovf = 0;
   bit         mdl_mm = 0;

   always #10 clk = ~clk;

   exp_port u_exp_port (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
      .dout_en(dout_en), .iorq_n(iorq_n), .mreq_n(mreq_n),
      .rd_n(rd_n), .wr_n(wr_n)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // Monitor: compares each acted-on read against the scoreboard queue
   always @(negedge clk) begin
      if (sample_req) begin
         logic [7:0] e;
         string t;
         sample_req = 0;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(dout_en == 1'b1, "R10 dout_en", {7'd0, dout_en}, 8'h01);
         check(dout == e, t, dout, e);
      end
   end

   task automatic bus_cycle(input bit io, input bit wr, input logic [15:0] a,
                            input logic [7:0] d, input bit claimed,
                            input int hold, input string tag);
      @(negedge clk);
      addr = a; din = d;
      iorq_n = !io; mreq_n = io;
      if (wr) wr_n = 1'b0; else rd_n = 1'b0;
      @(posedge clk); #1;
      if (!wr) begin
         if (claimed) sample_req = 1;
         else check(dout_en == 1'b0, tag, {7'd0, dout_en}, 8'h00);
      end
      for (int i = 1; i < hold; i++) @(posedge clk);
      @(negedge clk);
      iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic mdl_push(input logic [7:0] d);
      if (mdl.size() < 4) mdl.push_back(d);
      else mdl_ovf = 1;
   endtask

   function automatic logic [7:0] mdl_pop();
      if (mdl.size() == 0) return 8'hFF;
      return mdl.pop_front();
   endfunction

   task automatic wr_data(input bit io, input logic [15:0] a, input logic [7:0] d, input int hold);
      bus_cycle(io, 1, a, d, 1, hold, "");
      mdl_push(d);
   endtask

   task automatic rd_data(input bit io, input logic [15:0] a, input int hold, input string tag);
      exp_q.push_back(mdl_pop());
      tag_q.push_back(tag);
      bus_cycle(io, 0, a, 8'h00, 1, hold, tag);
   endtask

   task automatic wr_ctrl(input logic [7:0] d);
      bus_cycle(1, 1, 16'hF881, d, 1, 2, "");
      mdl_mm = d[0];
   endtask

   task automatic rd_ctrl(input string tag);
      exp_q.push_back({mdl_ovf, 6'd0, mdl_mm});
      tag_q.push_back(tag);
      bus_cycle(1, 0, 16'hF881, 8'h00, 1, 2, tag);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(dout_en == 1'b0, "R11 idle dout_en", {7'd0, dout_en}, 8'h00);
      rst_n = 1'b1;
      rd_ctrl("R11 control after reset");
      rd_data(1, 16'hF880, 2, "R6 empty read");

      // R4/R5: three bytes through the base data port
      wr_data(1, 16'hF880, 8'h11, 2);
      wr_data(1, 16'hF880, 8'h22, 2);
      wr_data(1, 16'hF880, 8'h33, 2);
      rd_data(1, 16'hF880, 2, "R5 order 0");
      rd_data(1, 16'hF880, 2, "R5 order 1");
      rd_data(1, 16'hF880, 2, "R4 order 2");

      // R3 aliases, R7 overflow on fifth write
      wr_data(1, 16'hF880, 8'hA1, 2);
      wr_data(1, 16'hF980, 8'hA2, 2);
      wr_data(1, 16'hFA80, 8'hA3, 2);
      wr_data(1, 16'hFB80, 8'hA4, 2);
      wr_data(1, 16'hF880, 8'h55, 2);
      rd_ctrl("R7 overflow flag");
      rd_data(1, 16'hFB80, 2, "R3 alias FB");
      rd_data(1, 16'hFA80, 2, "R3 alias FA");
      rd_data(1, 16'hF980, 2, "R3 alias F9");
      rd_data(1, 16'hF880, 2, "R7 kept data");
      rd_data(1, 16'hF880, 2, "R6 empty after drain");

      // R2: addresses that must not be claimed
      bus_cycle(1, 1, 16'hF480, 8'h01, 0, 2, "");
      bus_cycle(1, 1, 16'h7880, 8'h02, 0, 2, "");
      bus_cycle(1, 1, 16'hB880, 8'h03, 0, 2, "");
      bus_cycle(1, 1, 16'hF800, 8'h04, 0, 2, "");
      bus_cycle(1, 0, 16'hF480, 8'h00, 0, 2, "R2 A10 high");
      bus_cycle(1, 0, 16'h7880, 8'h00, 0, 2, "R2 A15 low");
      bus_cycle(1, 0, 16'hB880, 8'h00, 0, 2, "R2 A14 low");
      bus_cycle(1, 0, 16'hF800, 8'h00, 0, 2, "R2 A7 low");
      bus_cycle(1, 1, 16'hF882, 8'h05, 0, 2, "");
      bus_cycle(1, 0, 16'hF882, 8'h00, 0, 2, "R4 low bits mismatch");
      rd_data(1, 16'hF880, 2, "R2 nothing pushed");

      // R8 control register
      wr_ctrl(8'h01);
      rd_ctrl("R8 mode set");
      wr_ctrl(8'hFE);
      rd_ctrl("R8 mode clear");

      // R9 memory window
      bus_cycle(0, 1, 16'h4000, 8'h77, 0, 2, "");
      bus_cycle(0, 0, 16'h4000, 8'h00, 0, 2, "R9 mode off read");
      rd_data(1, 16'hF880, 2, "R9 mode off write ignored");
      wr_ctrl(8'h01);
      wr_data(0, 16'h4001, 8'h31, 2);
      wr_data(0, 16'h4003, 8'h32, 2);
      bus_cycle(0, 1, 16'h4004, 8'h99, 0, 2, "");
      bus_cycle(0, 0, 16'h4004, 8'h00, 0, 2, "R9 outside window");
      rd_data(1, 16'hF880, 2, "R9 io sees mem write");
      rd_data(0, 16'h4002, 2, "R9 mem read");
      rd_data(0, 16'h4000, 2, "R9 mem read empty");
      wr_ctrl(8'h00);

      // R1 long held strobes
      wr_data(1, 16'hF880, 8'hC1, 5);
      wr_data(1, 16'hF880, 8'hC2, 5);
      rd_data(1, 16'hF880, 5, "R1 held read 0");
      rd_data(1, 16'hF880, 5, "R1 held read 1");
      rd_data(1, 16'hF880, 5, "R1 held read empty");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R10 scoreboard drained", 8'(exp_q.size()), 8'h00);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule